// File: doc/BRIEF.md
# Arbitrary-Modulus Shift-Register Counter

This block counts modulo an arbitrary period with a handful of flip-flops and one XOR tree, in place of a binary counter with its carry chain. The count is held in a W-bit serial shift chain whose new bit is the XOR of chosen tap outputs. Left alone, such a chain walks through every nonzero state before it repeats. When one chosen state is reached, the block inverts the new bit. That jumps the chain back to its starting state, so the loop is shortened to exactly PERIOD states. The counter is suited to raster timing generators, where a line counter and a frame counter each need a few decoded event points.

The integrator gives only the tap mask, the period and a list of event positions, each counted as cycles after reset. The start state, the inversion state and every event pattern are worked out during elaboration. The index is defined as follows: index 0 is the state present in the cycle after reset. Each cycle with `en` high adds one to the index, modulo PERIOD. The outputs are the raw state, one registered decode per event and a registered terminal decode. The terminal decode also drives the inversion.

Top module: `lfsr_modulus_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows index 0. `state_o` holds the loop entry state, `term_o` is 0, and `match_o[k]` is 1 only when EVENT_AT[k] is 0.
- R2: With `en` held high, the states at indices 0 to PERIOD-1 are all distinct, and index PERIOD shows the same state as index 0. This holds for every PERIOD from 2 to 2^W-2.
- R3: `state_o` is never all zeros after reset.
- R4: `match_o[k]` is 1 exactly in the cycles where the index equals EVENT_AT[k]. Bit k of the vector belongs to entry k of the parameter list.
- R5: `term_o` is 1 exactly in the cycles where the index equals PERIOD-1. With `en` high, it is a single-cycle pulse once per period.
- R6: A clock edge with `en` low leaves `state_o`, `match_o` and `term_o` unchanged, and the index does not advance.
- R7: A reset applied in the middle of a count returns the counter to index 0 at the next edge, whatever the value of `en`.
- R8: On each edge with `en` high, bits W-1..1 of the new state equal bits W-2..0 of the old state. This is the serial shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to index 0 |
| en | input | 1 | Advance the count by one on this edge |
| state_o | output | W | Current shift-chain state |
| match_o | output | NUM_EVT | Registered decode: bit k is high while the index equals EVENT_AT[k] |
| term_o | output | 1 | Registered decode: high while the index equals PERIOD-1 |

## Verification
The properties assume that the tap mask describes a maximal-length feedback and that PERIOD lies between 2 and 2^W-2. They also assume that reset is asserted at the first clock, so that the start state is captured and later wraps can be compared against it. The stimulus keeps to these limits. The small instances all share one primitive 4-bit tap set and cover every legal period. The two 10-bit instances use a primitive tap set with the two raster-sized periods. `en` is held high for long runs, held low for a few cycles, and toggled in an irregular pattern. Reset is always applied synchronously.

// File: rtl/lfsr_mod_pkg.sv
package lfsr_mod_pkg;

  localparam int unsigned MAXW = 16;
  typedef logic [MAXW-1:0] lvec_t;

  function automatic lvec_t width_mask(int unsigned w);
    return lvec_t'((32'd1 << w) - 32'd1);
  endfunction

  // one plain step of the chain, no inversion
  function automatic lvec_t lfsr_next(lvec_t s, lvec_t taps, int unsigned w);
    logic fb;
    fb = ^(s & taps);
    return ((s << 1) | lvec_t'(fb)) & width_mask(w);
  endfunction

  function automatic lvec_t lfsr_advance(lvec_t s, lvec_t taps, int unsigned w,
                                         int unsigned n);
    lvec_t v;
    v = s;
    for (int unsigned i = 0; i < n; i++) v = lfsr_next(v, taps, w);
    return v;
  endfunction

  // Start state T of an m-state loop: inverting the new bit after m-1 plain
  // steps must land on T again, i.e. A^m T xor T == 1 over GF(2).
  function automatic lvec_t loop_entry(lvec_t taps, int unsigned w, int unsigned m);
    logic [MAXW-1:0][MAXW-1:0] cols;
    lvec_t acc;
    lvec_t tv;
    lvec_t res;
    logic  found;
    cols  = '0;
    res   = lvec_t'(1);
    found = 1'b0;
    for (int unsigned k = 0; k < w; k++)
      cols[4'(k)] = lfsr_advance(lvec_t'(1) << k, taps, w, m);
    for (int unsigned t = 1; t < (32'd1 << w); t++) begin
      tv  = lvec_t'(t);
      acc = '0;
      for (int unsigned k = 0; k < w; k++)
        if (((tv >> k) & lvec_t'(1)) != '0) acc = acc ^ cols[4'(k)];
      if (!found && ((acc ^ tv) == lvec_t'(1))) begin
        res   = tv;
        found = 1'b1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/lfsr_shift_core.sv
module lfsr_shift_core #(
  parameter int unsigned  W    = 10,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         flip,
  output logic [W-1:0] state_q,
  output logic [W-1:0] state_d
);

  logic fb;

  always_comb begin
    fb      = (^(state_q & TAPS)) ^ flip;
    state_d = en ? {state_q[W-2:0], fb} : state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/lfsr_state_decode.sv
module lfsr_state_decode #(
  parameter int unsigned  W       = 10,
  parameter logic [W-1:0] PAT     = 1,
  parameter bit           RST_HIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] nxt,
  output logic         hit_q
);

  // compares the state about to be loaded, so the flag lines up with it
  always_ff @(posedge clk) begin
    if (rst) hit_q <= RST_HIT;
    else     hit_q <= (nxt == PAT);
  end

endmodule

// File: rtl/lfsr_modulus_counter.sv
module lfsr_modulus_counter
  import lfsr_mod_pkg::*;
#(
  parameter int unsigned  W        = 10,
  parameter logic [W-1:0] TAPS     = 10'h240,
  parameter int unsigned  PERIOD   = 381,
  parameter int unsigned  NUM_EVT  = 4,
  parameter int unsigned  EVENT_AT [NUM_EVT] = '{288, 308, 353, 0}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [W-1:0]       state_o,
  output logic [NUM_EVT-1:0] match_o,
  output logic               term_o
);

  localparam lvec_t        TAPS_X  = lvec_t'(TAPS);
  localparam lvec_t        ENTRY_X = loop_entry(TAPS_X, W, PERIOD);
  localparam lvec_t        LAST_X  = lfsr_advance(ENTRY_X, TAPS_X, W, PERIOD - 1);
  localparam logic [W-1:0] ENTRY   = ENTRY_X[W-1:0];
  localparam logic [W-1:0] LAST    = LAST_X[W-1:0];

  logic [W-1:0] cur_q;
  logic [W-1:0] nxt;
  logic         last_hit;

  lfsr_shift_core #(
    .W(W), .TAPS(TAPS), .SEED(ENTRY)
  ) u_core (
    .clk(clk), .rst(rst), .en(en), .flip(last_hit),
    .state_q(cur_q), .state_d(nxt)
  );

  // registered terminal decode doubles as the inversion request
  lfsr_state_decode #(
    .W(W), .PAT(LAST), .RST_HIT(PERIOD == 1)
  ) u_last (
    .clk(clk), .rst(rst), .nxt(nxt), .hit_q(last_hit)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    localparam lvec_t PAT_X = lfsr_advance(ENTRY_X, TAPS_X, W, EVENT_AT[g] % PERIOD);
    lfsr_state_decode #(
      .W(W), .PAT(PAT_X[W-1:0]), .RST_HIT((EVENT_AT[g] % PERIOD) == 0)
    ) u_dec (
      .clk(clk), .rst(rst), .nxt(nxt), .hit_q(match_o[g])
    );
  end

  assign state_o = cur_q;
  assign term_o  = last_hit;

endmodule

// File: rtl/lfsr_modulus_counter_chk.sv
module lfsr_modulus_counter_chk #(
  parameter int unsigned W       = 10,
  parameter int unsigned NUM_EVT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [W-1:0]       state_o,
  input logic [NUM_EVT-1:0] match_o,
  input logic               term_o
);

  logic         cap_ok;
  logic [W-1:0] cap_state;

  // remember the index-0 state seen right after reset
  always_ff @(posedge clk) begin
    if (rst) cap_ok <= 1'b0;
    else if (!cap_ok) begin
      cap_ok    <= 1'b1;
      cap_state <= state_o;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!term_o && state_o != '0));

  p_wrap_to_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (term_o && en && cap_ok) |=> state_o == cap_state);

  p_never_zero_r3: assert property (@(posedge clk) disable iff (rst)
    state_o != '0);

  p_term_single_r5: assert property (@(posedge clk) disable iff (rst)
    (term_o && en) |=> !term_o);

  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(state_o) && $stable(match_o) && $stable(term_o)));

  p_shift_chain_r8: assert property (@(posedge clk) disable iff (rst)
    en |=> state_o[W-1:1] == $past(state_o[W-2:0]));

endmodule

bind lfsr_modulus_counter lfsr_modulus_counter_chk #(.W(W), .NUM_EVT(NUM_EVT)) u_chk (.*);

// File: tb/sim_lfsr_modulus_counter.sv
`timescale 1ns/1ps
module sim_lfsr_modulus_counter;

  localparam int N4 = 13;          // small units, periods 2..14
  localparam int NU = N4 + 2;      // plus two 10-bit units

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #5 clk = ~clk;

  logic [9:0] st10 [2];
  logic [3:0] mt10 [2];
  logic       tm10 [2];
  logic [3:0] st4  [N4];
  logic [3:0] mt4  [N4];
  logic       tm4  [N4];

  lfsr_modulus_counter u0 (
    .clk(clk), .rst(rst), .en(en),
    .state_o(st10[0]), .match_o(mt10[0]), .term_o(tm10[0]));

  lfsr_modulus_counter #(
    .W(10), .TAPS(10'h240), .PERIOD(528), .NUM_EVT(4), .EVENT_AT('{455, 486, 488, 0})
  ) u1 (
    .clk(clk), .rst(rst), .en(en),
    .state_o(st10[1]), .match_o(mt10[1]), .term_o(tm10[1]));

  for (genvar g = 0; g < N4; g++) begin : g_small
    lfsr_modulus_counter #(
      .W(4), .TAPS(4'hC), .PERIOD(g + 2), .NUM_EVT(4),
      .EVENT_AT('{0, 1, (g + 2) / 2, g + 1})
    ) u4 (
      .clk(clk), .rst(rst), .en(en),
      .state_o(st4[g]), .match_o(mt4[g]), .term_o(tm4[g]));
  end

  int unsigned adv = 0;
  int          vectors = 0;
  int          errors = 0;
  bit          done = 1'b0;
  int          off [NU];
  logic [9:0]  hist [1024];
  bit          filled [1024];
  bit [1023:0] seen [NU];
  logic [9:0]  prev [NU];

  function automatic int unsigned unit_m(int u);
    if (u == 0) return 381;
    if (u == 1) return 528;
    return u;
  endfunction

  function automatic int unsigned unit_ev(int u, int k);
    if (u == 0) begin
      case (k) 0: return 288; 1: return 308; 2: return 353; default: return 0; endcase
    end
    if (u == 1) begin
      case (k) 0: return 455; 1: return 486; 2: return 488; default: return 0; endcase
    end
    case (k) 0: return 0; 1: return 1; 2: return u / 2; default: return u - 1; endcase
  endfunction

  task automatic chk(bit ok, string req, int u, int unsigned idx,
                     logic [9:0] act, logic [9:0] expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s unit %0d index %0d actual %0h expected %0h", req, u, idx, act, expv);
    end
  endtask

  // mode 0: after reset, 1: after an enabled edge, 2: after an idle edge
  task automatic sample(int mode, string req);
    for (int u = 0; u < NU; u++) begin
      int unsigned m;
      int unsigned idx;
      int          pos;
      logic [9:0]  st;
      logic [9:0]  wm;
      logic [3:0]  mt;
      logic [3:0]  emt;
      logic        tm;
      m   = unit_m(u);
      idx = adv % m;
      if (u < 2) begin
        st = st10[u]; mt = mt10[u]; tm = tm10[u]; wm = 10'h3FF;
      end else begin
        st = {6'd0, st4[u-2]}; mt = mt4[u-2]; tm = tm4[u-2]; wm = 10'h00F;
      end
      for (int k = 0; k < 4; k++) emt[k] = (idx == unit_ev(u, k));
      chk(st != '0, "R3", u, idx, st, 10'h001);
      chk(mt == emt, "R4", u, idx, {6'd0, mt}, {6'd0, emt});
      chk(tm == (idx == m - 1), "R5", u, idx, {9'd0, tm}, {9'd0, idx == m - 1});
      if (mode == 1) chk((st >> 1) == (prev[u] & (wm >> 1)), "R8", u, idx, st >> 1, prev[u] & (wm >> 1));
      if (mode == 2) chk(st == prev[u], "R6", u, idx, st, prev[u]);
      pos = off[u] + int'(idx);
      if (filled[pos]) chk(st == hist[pos], req, u, idx, st, hist[pos]);
      else begin
        chk(!seen[u][st], "R2", u, idx, st, 10'h000);
        seen[u][st] = 1'b1;
        hist[pos]   = st;
        filled[pos] = 1'b1;
      end
      prev[u] = st;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    off[0] = 0;
    for (int u = 1; u < NU; u++) off[u] = off[u-1] + int'(unit_m(u - 1));
    for (int i = 0; i < 1024; i++) filled[i] = 1'b0;
    for (int u = 0; u < NU; u++) seen[u] = '0;

    // R1: reset state at index 0
    rst = 1'b1; en = 1'b0;
    tick(); tick();
    adv = 0;
    sample(0, "R1");
    rst = 1'b0;

    // R2: two full periods of the longest loop, continuous advance
    en = 1'b1;
    for (int i = 0; i < 1060; i++) begin
      tick(); adv++; sample(1, "R2");
    end

    // R6: idle edges hold everything
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(); sample(2, "R6");
    end

    // R6 and R2: irregular enable pattern
    for (int i = 0; i < 300; i++) begin
      en = ((i % 3) != 1) && ((i % 7) != 5);
      tick();
      if (en) begin adv++; sample(1, "R2"); end
      else sample(2, "R6");
    end

    // R7: reset in mid count with enable high
    en = 1'b1; rst = 1'b1;
    tick(); adv = 0; sample(0, "R7");
    rst = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tick(); adv++; sample(1, "R7");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule